// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block owns the control word of a clock synthesizer. The word has three parts: a 9-bit feedback divider value, a 2-bit output divider code, and a 2-bit selector for a diagnostic test pin. Software or board straps can write the word along two competing paths.

The parallel path takes the divider values from dedicated pins while a load-enable pin is low, and freezes them when that pin rises. The serial path shifts a 14-bit frame in from a data pin, one bit per rising edge of a slow serial clock. A strobe then commits the frame. While the strobe is held high, the commit is transparent and happens on every serial clock.

All pins are asynchronous. They are brought into the block clock through a bank of synchronizers, and every edge is detected on the synchronized copies. Whichever load event came last decides the word. A registered flag warns when the feedback value lies outside the lock window. A registered test pin shows one of four sources, chosen by the selector bits.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: While `rst` is high, and for the cycle after it, the feedback value is 20, the output code is 0 and the test selector is 00; `test_o` and `m_range_err_o` are low.
- R2: While `par_load_n_i` is low, `m_o` and `n_o` follow `par_m_i` and `par_n_i`, a few cycles later.
- R3: A rise of `par_load_n_i` freezes the values last taken from the pins. Later changes on `par_m_i` and `par_n_i` have no effect until `par_load_n_i` goes low again or a serial commit happens.
- R4: While `par_load_n_i` is high, each rising edge of `ser_clk_i` shifts `ser_data_i` into a 14-bit frame. The bits are sent most significant first, in this order: test select high bit, test select low bit, one null bit, output code high bit, output code low bit, then feedback bits 8 down to 0. The value of the null bit never reaches any output.
- R5: A rise of `ser_strobe_i` in serial mode commits the frame to `m_o`, `n_o` and the test selector. Frames shifted before the strobe rises do not change the outputs. After the strobe falls, further shifting leaves the committed values unchanged.
- R6: While `ser_strobe_i` is high in serial mode, every serial clock rise commits the newly shifted frame at once.
- R7: In serial mode `test_o` shows one of four sources, chosen by the selector: 00 gives low, 01 gives the serial data input, 10 gives `fb_div_i`, and 11 gives `out_clk_i`.
- R8: `test_o` is low whenever `par_load_n_i` is low.
- R9: `m_range_err_o` is high exactly when `m_o` is below 10 or above 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| par_load_n_i | input | 1 | Parallel load enable, active low; its rise freezes the pin values |
| par_m_i | input | 9 | Feedback divider value on pins |
| par_n_i | input | 2 | Output divider code on pins |
| ser_clk_i | input | 1 | Serial shift clock, slow relative to `clk` |
| ser_data_i | input | 1 | Serial frame data |
| ser_strobe_i | input | 1 | Serial commit strobe |
| fb_div_i | input | 1 | Feedback divider output, routed to the test pin |
| out_clk_i | input | 1 | Output clock, routed to the test pin |
| m_o | output | 9 | Active feedback divider value |
| n_o | output | 2 | Active output divider code |
| test_o | output | 1 | Diagnostic output |
| m_range_err_o | output | 1 | Feedback value outside the lock window |

## Verification
Some properties are checked on every cycle by assertions:
- the reset defaults;
- the word staying stable whenever no load event is present;
- the serial bit entering the frame;
- the shift register staying idle in parallel mode;
- the test pin staying low in parallel mode or when the selector is 00;
- the range flag agreeing with the held value.

Other behaviour needs whole bench scenarios:
- the frame bit order;
- the null bit having no effect;
- the last-load-wins interplay between the parallel freeze and a serial commit;
- the transparent strobe mode;
- the routing of each test source.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned M_W     = 9;
  localparam int unsigned N_W     = 2;
  localparam int unsigned T_W     = 2;
  localparam int unsigned NULL_W  = 1;
  localparam int unsigned FRAME_W = T_W + NULL_W + N_W + M_W;

  // Bit positions inside a received frame (first bit sent ends up at the top)
  localparam int unsigned M_LSB = 0;
  localparam int unsigned N_LSB = M_W;
  localparam int unsigned T_LSB = M_W + N_W + NULL_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_OCLK  = 2'b11
  } tsel_e;

  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_en_i,
  input  logic               sclk_i,
  input  logic               strobe_i,
  input  logic               sdata_i,
  output logic [FRAME_W-1:0] frame_next_o,
  output logic               commit_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic               sclk_q, strobe_q;
  logic               sclk_rise, strobe_rise, shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      shreg_q  <= '0;
    end else begin
      sclk_q   <= sclk_i;
      strobe_q <= strobe_i;
      shreg_q  <= frame_next_o;
    end
  end

  assign sclk_rise   = sclk_i & ~sclk_q;
  assign strobe_rise = strobe_i & ~strobe_q;
  assign shift_en    = ser_en_i & sclk_rise;

  always_comb begin
    frame_next_o = shreg_q;
    if (shift_en) frame_next_o = {shreg_q[FRAME_W-2:0], sdata_i};
  end

  // Commit on strobe rise, or on every shift while the strobe is held high
  assign commit_o = ser_en_i & (strobe_rise | (strobe_i & sclk_rise));

  // R4
  shreg_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_en_i |=> $stable(shreg_q));
  // R4
  shreg_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> shreg_q[0] == $past(sdata_i));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter logic [M_W-1:0] DEF_M    = 9'd20,
  parameter logic [N_W-1:0] DEF_N    = '0,
  parameter logic [T_W-1:0] DEF_T    = '0,
  parameter int unsigned    LOCK_MIN = 10,
  parameter int unsigned    LOCK_MAX = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_en_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output cfg_word_t          word_o,
  output logic               range_err_o
);
  localparam cfg_word_t DEF_WORD = '{tsel: DEF_T, n: DEF_N, m: DEF_M};

  cfg_word_t word_q, word_d;
  logic      err_q;

  always_comb begin
    word_d = word_q;
    if (!ser_en_i) begin
      word_d.m = par_m_i;
      word_d.n = par_n_i;
    end else if (commit_i) begin
      word_d.m    = frame_i[M_LSB +: M_W];
      word_d.n    = frame_i[N_LSB +: N_W];
      word_d.tsel = frame_i[T_LSB +: T_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= DEF_WORD;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      err_q  <= (32'(word_d.m) < LOCK_MIN) || (32'(word_d.m) > LOCK_MAX);
    end
  end

  assign word_o      = word_q;
  assign range_err_o = err_q;

  // R1
  rst_def_chk: assert property (@(posedge clk)
    rst |=> (word_q == DEF_WORD) && !err_q);
  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en_i && !commit_i) |=> $stable(word_q));
  // R9
  range_flag_chk: assert property (@(posedge clk) disable iff (rst)
    err_q == ((32'(word_q.m) < LOCK_MIN) || (32'(word_q.m) > LOCK_MAX)));
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ser_en_i,
  input  tsel_e tsel_i,
  input  logic  sdata_i,
  input  logic  fb_div_i,
  input  logic  out_clk_i,
  output logic  test_o
);
  logic test_q, test_d;

  always_comb begin
    test_d = 1'b0;
    if (ser_en_i) begin
      unique case (tsel_i)
        TSEL_LOW:   test_d = 1'b0;
        TSEL_SDATA: test_d = sdata_i;
        TSEL_FBDIV: test_d = fb_div_i;
        TSEL_OCLK:  test_d = out_clk_i;
        default:    test_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) test_q <= 1'b0;
    else     test_q <= test_d;
  end

  assign test_o = test_q;

  // R8
  test_par_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_en_i |=> !test_q);
  // R7
  test_sel_low_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel_i == TSEL_LOW) |=> !test_q);
  // R7
  test_sdata_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en_i && tsel_i == TSEL_SDATA) |=> test_q == $past(sdata_i));
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEF_M       = 20,
  parameter int unsigned LOCK_MIN    = 10,
  parameter int unsigned LOCK_MAX    = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_strobe_i,
  input  logic           fb_div_i,
  input  logic           out_clk_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic           test_o,
  output logic           m_range_err_o
);
  localparam int unsigned PIN_W = 4 + M_W + N_W;
  // Load enable idles high so reset defaults survive until pins drive it low
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, {(PIN_W-1){1'b0}}};

  logic [PIN_W-1:0]   pins_raw, pins_s;
  logic               pload_n_s, sclk_s, sdata_s, strobe_s;
  logic [M_W-1:0]     pm_s;
  logic [N_W-1:0]     pn_s;
  logic [FRAME_W-1:0] frame_next;
  logic               commit;
  cfg_word_t          word;

  assign pins_raw = {par_load_n_i, ser_clk_i, ser_data_i, ser_strobe_i, par_m_i, par_n_i};

  cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  assign {pload_n_s, sclk_s, sdata_s, strobe_s, pm_s, pn_s} = pins_s;

  cfg_shift u_shift (
    .clk          (clk),
    .rst          (rst),
    .ser_en_i     (pload_n_s),
    .sclk_i       (sclk_s),
    .strobe_i     (strobe_s),
    .sdata_i      (sdata_s),
    .frame_next_o (frame_next),
    .commit_o     (commit)
  );

  cfg_regs #(
    .DEF_M    (M_W'(DEF_M)),
    .DEF_N    ('0),
    .DEF_T    ('0),
    .LOCK_MIN (LOCK_MIN),
    .LOCK_MAX (LOCK_MAX)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .ser_en_i    (pload_n_s),
    .par_m_i     (pm_s),
    .par_n_i     (pn_s),
    .commit_i    (commit),
    .frame_i     (frame_next),
    .word_o      (word),
    .range_err_o (m_range_err_o)
  );

  cfg_test_mux u_test (
    .clk       (clk),
    .rst       (rst),
    .ser_en_i  (pload_n_s),
    .tsel_i    (tsel_e'(word.tsel)),
    .sdata_i   (sdata_s),
    .fb_div_i  (fb_div_i),
    .out_clk_i (out_clk_i),
    .test_o    (test_o)
  );

  assign m_o = word.m;
  assign n_o = word.n;

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (m_o == $past(frame_next[M_W-1:0])));
endmodule

// File: tb/synth_cfg_ctrl_bench.sv
module synth_cfg_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pload_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [8:0] pm = '0;
  logic [1:0] pn = '0;
  logic       fb = 1'b0, oc = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic       test_o, err_o;

  int total = 0, fails = 0;
  bit done = 0;
  logic [13:0] mdl = '0;

  always #5 clk = ~clk;

  synth_cfg_ctrl u_synth_cfg_ctrl (
    .clk(clk), .rst(rst), .par_load_n_i(pload_n), .par_m_i(pm), .par_n_i(pn),
    .ser_clk_i(sclk), .ser_data_i(sdata), .ser_strobe_i(sload),
    .fb_div_i(fb), .out_clk_i(oc), .m_o(m_o), .n_o(n_o),
    .test_o(test_o), .m_range_err_o(err_o)
  );

  function automatic bit exp_err(input int m);
    return (m < 10) || (m > 28);
  endfunction

  function automatic logic [13:0] frame(input logic [1:0] t, input logic nul,
                                        input logic [1:0] n, input logic [8:0] m);
    return {t, nul, n, m};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_cfg(input int m, input int n, input string req);
    check(m_o == m, req, m_o, m);
    check(n_o == n, req, n_o, n);
    check(err_o == exp_err(m), {req, "/R9"}, err_o, exp_err(m));
  endtask

  task automatic send_bit(input logic b);
    sdata = b; tick(4);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(2);
    mdl = {mdl[12:0], b};
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_strobe();
    sload = 1'b1; tick(6);
    sload = 1'b0; tick(6);
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    pload_n = 1'b0; pm = m; pn = n; tick(6);
    pload_n = 1'b1; tick(6);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(4);
    // R1 defaults during and after reset
    check_cfg(20, 0, "R1");
    check(test_o == 1'b0, "R1 test", test_o, 0);
    rst = 1'b0; tick(6);
    check_cfg(20, 0, "R1");

    // R2 pins follow while enable low
    pload_n = 1'b0; pm = 9'd100; pn = 2'd3; tick(6);
    check_cfg(100, 3, "R2");
    pm = 9'd17; pn = 2'd1; tick(6);
    check_cfg(17, 1, "R2");
    // R3 freeze on rise, pins ignored afterwards
    pload_n = 1'b1; tick(6);
    pm = 9'd200; pn = 2'd2; tick(6);
    check_cfg(17, 1, "R3");

    // R9 boundaries via parallel path
    par_load(9'd9, 2'd0);   check_cfg(9, 0, "R9");
    par_load(9'd10, 2'd0);  check_cfg(10, 0, "R9");
    par_load(9'd28, 2'd0);  check_cfg(28, 0, "R9");
    par_load(9'd29, 2'd0);  check_cfg(29, 0, "R9");
    par_load(9'd511, 2'd2); check_cfg(511, 2, "R9");

    // R4/R5 serial frame: no change before strobe, commit on rise
    send_frame(frame(2'b00, 1'b0, 2'd1, 9'd25));
    check_cfg(511, 2, "R5 pre-strobe");
    pulse_strobe();
    check_cfg(25, 1, "R5");
    // R5 shifting after strobe fell keeps committed values
    send_frame(frame(2'b00, 1'b0, 2'd3, 9'd300));
    check_cfg(25, 1, "R5 hold");
    // R3 serial commit overrides a parallel freeze
    pulse_strobe();
    check_cfg(300, 3, "R3 serial");
    // R4 null bit ignored
    send_frame(frame(2'b00, 1'b1, 2'd2, 9'd12)); pulse_strobe();
    check_cfg(12, 2, "R4 null1");
    check(test_o == 1'b0, "R4 null tsel", test_o, 0);
    send_frame(frame(2'b00, 1'b0, 2'd2, 9'd12)); pulse_strobe();
    check_cfg(12, 2, "R4 null0");

    // R6 transparent strobe
    sload = 1'b1; tick(6);
    check_cfg(mdl[8:0], mdl[10:9], "R6 rise");
    for (int i = 0; i < 6; i++) begin
      send_bit(logic'(($urandom() & 1)));
      check_cfg(mdl[8:0], mdl[10:9], "R6");
    end
    sload = 1'b0; tick(6);

    // R7 test sources
    send_frame(frame(2'b01, 1'b0, 2'd0, 9'd20)); pulse_strobe();
    sdata = 1'b1; tick(6); check(test_o == 1'b1, "R7 sdata", test_o, 1);
    sdata = 1'b0; tick(6); check(test_o == 1'b0, "R7 sdata", test_o, 0);
    send_frame(frame(2'b10, 1'b0, 2'd0, 9'd20)); pulse_strobe();
    fb = 1'b1; tick(4); check(test_o == 1'b1, "R7 fbdiv", test_o, 1);
    fb = 1'b0; tick(4); check(test_o == 1'b0, "R7 fbdiv", test_o, 0);
    send_frame(frame(2'b11, 1'b0, 2'd0, 9'd20)); pulse_strobe();
    oc = 1'b1; tick(4); check(test_o == 1'b1, "R7 oclk", test_o, 1);
    // R8 low in parallel mode even with a high source
    pload_n = 1'b0; pm = 9'd20; pn = 2'd0; tick(6);
    check(test_o == 1'b0, "R8", test_o, 0);
    pload_n = 1'b1; tick(6);
    check(test_o == 1'b1, "R7 oclk back", test_o, 1);
    send_frame(frame(2'b00, 1'b0, 2'd0, 9'd20)); pulse_strobe();
    fb = 1'b1; tick(6);
    check(test_o == 1'b0, "R7 low", test_o, 0);
    oc = 1'b0; fb = 1'b0;

    // random serial frames (R4, R5)
    for (int k = 0; k < 20; k++) begin
      logic [8:0] rm = 9'($urandom());
      logic [1:0] rn = 2'($urandom());
      send_frame(frame(2'b00, 1'($urandom()), rn, rm)); pulse_strobe();
      check_cfg(rm, rn, "R4/R5 rnd");
    end
    // random parallel loads (R2, R3)
    for (int k = 0; k < 20; k++) begin
      logic [8:0] rm = 9'($urandom());
      logic [1:0] rn = 2'($urandom());
      par_load(rm, rn);
      pm = ~rm; tick(6);
      check_cfg(rm, rn, "R2/R3 rnd");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule